// File: doc/BRIEF.md
# Two-Wire Sensor Register Port

This block is the serial slave front end of a small sensor. It watches the SCL and SDA lines of a two-wire bus (I2C and SMBus compatible) and drives SDA only through an open-drain pull-down enable. Both lines are resynchronised and majority-filtered on the system clock. START, STOP and clock edges are then taken from the clean copies. A state machine decodes three addresses: the device's own address, the general-call address and the SMBus alert-response address. It holds a 2-bit register pointer and moves 16-bit registers one byte at a time, upper byte first.

The core sees a plain register port. The pointer selects the register, the core returns its read data, and every accepted data byte arrives as a one-cycle write strobe tagged upper or lower. The core also gets three one-cycle strobes: a general-call reset command, the acknowledgement of any read address, and a won alert-response arbitration.

States: `ST_IDLE` (bus free), `ST_ADDR` (address byte shifting in), `ST_PTR` (pointer byte), `ST_WDATA` (data byte for the selected register), `ST_GCCMD` (general-call command byte), `ST_RACK` (the block drives the acknowledge bit), `ST_TX` (a register byte shifting out), `ST_MACK` (the master's acknowledge being sampled), `ST_ARA` (own address shifting out with arbitration), `ST_WAIT_STOP` (ignoring the bus until STOP or START). Transitions: a START from any state goes to `ST_ADDR`. A STOP from any state, or an SCL-low timeout, goes to `ST_IDLE`. A matching byte goes through `ST_RACK` to the successor chosen at decode. A non-matching byte goes to `ST_WAIT_STOP`. `ST_TX` goes to `ST_MACK` after eight bits. An ACK on the upper byte sends `ST_MACK` back to `ST_TX` for the lower byte; otherwise `ST_MACK` goes to `ST_WAIT_STOP`. Lost arbitration or eight sent bits take `ST_ARA` to `ST_WAIT_STOP`.

Top module: `tw_sensor_port`

## Requirements
- R1: While reset is held, and after it is released, SDA is not driven, the pointer output is 00 and no strobe is high.
- R2: The block acknowledges an address byte whose upper seven bits are 1001 0 followed by the 2-bit strap input (strap in bits 1:0 of the address). Any other address that is not a general call or an alert response is not acknowledged.
- R3: The low two bits of the first byte after a write address become the pointer (00 temperature, 01 configuration, 10 low limit, 11 high limit). The pointer is kept across transactions, so a later read uses it without a new pointer byte.
- R4: A read sends the selected register's bits 15:8 first, then bits 7:0, each MSB first. A master NACK after either byte ends the transfer. Each acknowledged read address raises the any-read strobe for one cycle.
- R5: Data bytes after the pointer each raise one write strobe. The first is marked upper and the second lower. A STOP after one data byte leaves the lower byte untouched.
- R6: Data bytes sent while the pointer is 00 are acknowledged, but no write strobe is raised.
- R7: The general-call address (all zero, write) is acknowledged. A second byte of 0x06 raises the reset strobe and returns the pointer to 00. Any other second byte raises nothing.
- R8: A read to 0001100 is acknowledged only while the alert input is high. The reply byte is the own 7-bit address followed by the alert-cause input as bit 0.
- R9: While sending the reply, a released bit that reads back as 0 means lost arbitration. The block stops driving and raises no win strobe. A reply sent to the end raises the win strobe at the next STOP.
- R10: A first byte of the form 00001xxx is not acknowledged, and a repeated START that follows is decoded normally.
- R11: When SCL stays low for TIMEOUT_TICKS clock cycles, the block releases SDA and returns to idle.
- R12: The block starts driving SDA only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe_o | output | 1 | High pulls SDA low |
| strap_i | input | 2 | Address strap, the two low address bits |
| alert_i | input | 1 | Alert currently active in the core |
| alert_cause_i | input | 1 | Status bit returned in the alert reply |
| reg_sel_o | output | 2 | Register pointer |
| reg_rd_data_i | input | 16 | Read data of the selected register |
| reg_wr_en_o | output | 1 | One-cycle write strobe |
| reg_wr_hi_o | output | 1 | Write targets bits 15:8 (else 7:0) |
| reg_wr_data_o | output | 8 | Write byte |
| gc_reset_o | output | 1 | General-call reset strobe |
| any_read_o | output | 1 | Read address acknowledged strobe |
| alert_win_o | output | 1 | Alert reply won, strobe at STOP |

## Verification
The hardest case to reach is lost arbitration during the alert reply. It needs a second bus device that pulls SDA low while this block releases a 1. The bench models that rival as an extra pull-down on the shared line. It holds the pull-down through a whole reply byte and records whether the block drives again on any later zero bit. The SCL-low timeout is reached by stalling the clock mid-read, with the block driving a data 0, for longer than a reduced TIMEOUT_TICKS.

// File: rtl/tw_pkg.sv
package tw_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_PTR,
        ST_WDATA,
        ST_GCCMD,
        ST_RACK,
        ST_TX,
        ST_MACK,
        ST_ARA,
        ST_WAIT_STOP
    } tw_state_e;

    localparam int REG_W   = 16;
    localparam int BYTE_W  = 8;
    localparam logic [4:0] DEV_ADDR_HI  = 5'b10010;
    localparam logic [6:0] GC_ADDR      = 7'b0000000;
    localparam logic [6:0] ARA_ADDR     = 7'b0001100;
    localparam logic [7:0] GC_RESET_CMD = 8'h06;
endpackage

// File: rtl/tw_line_filter.sv
module tw_line_filter #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic [2:0]             win_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            win_q  <= '1;
            line_o <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
            win_q  <= {win_q[1:0], sync_q[SYNC_STAGES-1]};
            line_o <= (win_q[0] & win_q[1]) | (win_q[1] & win_q[2]) | (win_q[0] & win_q[2]);
        end
    end
endmodule

// File: rtl/tw_bus_events.sv
module tw_bus_events #(
    parameter int TIMEOUT_TICKS = 3000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f_i,
    input  logic sda_f_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o,
    output logic timeout_o
);
    localparam int CW = $clog2(TIMEOUT_TICKS + 1);
    localparam logic [CW-1:0] LIMIT    = CW'(TIMEOUT_TICKS);
    localparam logic [CW-1:0] LIMIT_M1 = CW'(TIMEOUT_TICKS - 1);

    logic          scl_q, sda_q;
    logic [CW-1:0] low_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q     <= 1'b1;
            sda_q     <= 1'b1;
            low_cnt_q <= '0;
        end else begin
            scl_q <= scl_f_i;
            sda_q <= sda_f_i;
            if (scl_f_i)
                low_cnt_q <= '0;
            else if (low_cnt_q != LIMIT)
                low_cnt_q <= low_cnt_q + 1'b1;
        end
    end

    assign scl_rise_o = scl_f_i & ~scl_q;
    assign scl_fall_o = ~scl_f_i & scl_q;
    assign start_o    = scl_f_i & scl_q & sda_q & ~sda_f_i;
    assign stop_o     = scl_f_i & scl_q & ~sda_q & sda_f_i;
    assign timeout_o  = ~scl_f_i & (low_cnt_q == LIMIT_M1);
endmodule

// File: rtl/tw_sensor_port.sv
module tw_sensor_port
    import tw_pkg::*;
#(
    parameter int TIMEOUT_TICKS = 3000000,
    parameter int SYNC_STAGES   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic [1:0]        strap_i,
    input  logic              alert_i,
    input  logic              alert_cause_i,
    output logic [1:0]        reg_sel_o,
    input  logic [REG_W-1:0]  reg_rd_data_i,
    output logic              reg_wr_en_o,
    output logic              reg_wr_hi_o,
    output logic [BYTE_W-1:0] reg_wr_data_o,
    output logic              gc_reset_o,
    output logic              any_read_o,
    output logic              alert_win_o
);
    localparam int HALF = REG_W / 2;

    logic scl_f, sda_f, scl_rise, scl_fall, start_det, stop_det, tmo;

    tw_line_filter #(.SYNC_STAGES(SYNC_STAGES)) u_scl_filt (
        .clk(clk), .rst_n(rst_n), .line_i(scl_i), .line_o(scl_f));
    tw_line_filter #(.SYNC_STAGES(SYNC_STAGES)) u_sda_filt (
        .clk(clk), .rst_n(rst_n), .line_i(sda_i), .line_o(sda_f));

    tw_bus_events #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_events (
        .clk(clk), .rst_n(rst_n), .scl_f_i(scl_f), .sda_f_i(sda_f),
        .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
        .start_o(start_det), .stop_o(stop_det), .timeout_o(tmo));

    tw_state_e         state_q, ret_q;
    logic [7:0]        shreg_q, txsh_q;
    logic [3:0]        bitcnt_q;
    logic [1:0]        ptr_q, widx_q;
    logic              rd_second_q, mack_q, ara_won_q;
    logic [6:0]        own_addr;

    assign own_addr = {DEV_ADDR_HI, strap_i};

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q       <= ST_IDLE;
            ret_q         <= ST_IDLE;
            shreg_q       <= '0;
            txsh_q        <= '1;
            bitcnt_q      <= '0;
            ptr_q         <= 2'b00;
            widx_q        <= '0;
            rd_second_q   <= 1'b0;
            mack_q        <= 1'b1;
            ara_won_q     <= 1'b0;
            reg_wr_en_o   <= 1'b0;
            reg_wr_hi_o   <= 1'b0;
            reg_wr_data_o <= '0;
            gc_reset_o    <= 1'b0;
            any_read_o    <= 1'b0;
            alert_win_o   <= 1'b0;
        end else begin
            reg_wr_en_o <= 1'b0;
            gc_reset_o  <= 1'b0;
            any_read_o  <= 1'b0;
            alert_win_o <= 1'b0;
            if (tmo) begin
                state_q   <= ST_IDLE;
                ara_won_q <= 1'b0;
            end else if (start_det) begin
                state_q   <= ST_ADDR;
                bitcnt_q  <= '0;
                ara_won_q <= 1'b0;
            end else if (stop_det) begin
                state_q     <= ST_IDLE;
                alert_win_o <= ara_won_q;
                ara_won_q   <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_IDLE, ST_WAIT_STOP: ;
                    ST_ADDR, ST_PTR, ST_WDATA, ST_GCCMD: begin
                        if (scl_rise && bitcnt_q != 4'd8) begin
                            shreg_q  <= {shreg_q[6:0], sda_f};
                            bitcnt_q <= bitcnt_q + 4'd1;
                        end else if (scl_fall && bitcnt_q == 4'd8) begin
                            bitcnt_q <= '0;
                            state_q  <= ST_RACK;
                            if (state_q == ST_ADDR) begin
                                if (shreg_q[7:1] == own_addr) begin
                                    ret_q      <= shreg_q[0] ? ST_TX : ST_PTR;
                                    any_read_o <= shreg_q[0];
                                end else if (shreg_q == {GC_ADDR, 1'b0}) begin
                                    ret_q <= ST_GCCMD;
                                end else if (shreg_q == {ARA_ADDR, 1'b1} && alert_i) begin
                                    ret_q <= ST_ARA;
                                end else begin
                                    state_q <= ST_WAIT_STOP;
                                end
                            end else if (state_q == ST_PTR) begin
                                ptr_q  <= shreg_q[1:0];
                                widx_q <= '0;
                                ret_q  <= ST_WDATA;
                            end else if (state_q == ST_WDATA) begin
                                ret_q <= ST_WDATA;
                                if (widx_q != 2'd2) begin
                                    widx_q        <= widx_q + 2'd1;
                                    reg_wr_en_o   <= (ptr_q != 2'b00);
                                    reg_wr_hi_o   <= (widx_q == 2'd0);
                                    reg_wr_data_o <= shreg_q;
                                end
                            end else begin
                                ret_q <= ST_WAIT_STOP;
                                if (shreg_q == GC_RESET_CMD) begin
                                    gc_reset_o <= 1'b1;
                                    ptr_q      <= 2'b00;
                                end
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_fall) begin
                            state_q  <= ret_q;
                            bitcnt_q <= '0;
                            if (ret_q == ST_TX) begin
                                txsh_q      <= reg_rd_data_i[REG_W-1:HALF];
                                rd_second_q <= 1'b0;
                            end else if (ret_q == ST_ARA) begin
                                txsh_q <= {own_addr, alert_cause_i};
                            end
                        end
                    end
                    ST_TX, ST_ARA: begin
                        if (scl_rise && state_q == ST_ARA && txsh_q[7] && !sda_f) begin
                            state_q <= ST_WAIT_STOP;
                        end else if (scl_fall) begin
                            if (bitcnt_q == 4'd7) begin
                                bitcnt_q <= '0;
                                if (state_q == ST_TX) begin
                                    state_q <= ST_MACK;
                                end else begin
                                    state_q   <= ST_WAIT_STOP;
                                    ara_won_q <= 1'b1;
                                end
                            end else begin
                                txsh_q   <= {txsh_q[6:0], 1'b1};
                                bitcnt_q <= bitcnt_q + 4'd1;
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) begin
                            mack_q <= sda_f;
                        end else if (scl_fall) begin
                            if (!mack_q && !rd_second_q) begin
                                txsh_q      <= reg_rd_data_i[HALF-1:0];
                                rd_second_q <= 1'b1;
                                bitcnt_q    <= '0;
                                state_q     <= ST_TX;
                            end else begin
                                state_q <= ST_WAIT_STOP;
                            end
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        sda_oe_o  = 1'b0;
        reg_sel_o = ptr_q;
        unique case (state_q)
            ST_RACK:       sda_oe_o = 1'b1;
            ST_TX, ST_ARA: sda_oe_o = ~txsh_q[7];
            default:       sda_oe_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/tw_sensor_port_chk.sv
module tw_sensor_port_chk #(
    parameter int TIMEOUT_TICKS = 3000000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       sda_oe_o,
    input logic [1:0] reg_sel_o,
    input logic       reg_wr_en_o,
    input logic       gc_reset_o,
    input logic       any_read_o,
    input logic       alert_win_o
);
    localparam int LIM = TIMEOUT_TICKS + 16;
    localparam int CW  = $clog2(LIM + 2);

    logic [CW-1:0] low_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            low_q <= '0;
        else if (scl_i)
            low_q <= '0;
        else if (low_q != CW'(LIM + 1))
            low_q <= low_q + 1'b1;
    end

    always_comb begin
        if (!rst_n) begin
            AST_RESET_RELEASED: assert (!sda_oe_o && !reg_wr_en_o); // R1
        end
    end

    AST_NO_TEMP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en_o |-> reg_sel_o != 2'b00); // R6

    AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en_o |=> !reg_wr_en_o); // R5

    AST_STROBES_APART: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_wr_en_o, gc_reset_o, any_read_o, alert_win_o})); // R4

    AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !scl_i); // R12

    AST_WIN_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        alert_win_o |-> !sda_oe_o); // R9

    AST_TIMEOUT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (low_q > CW'(LIM)) |-> !sda_oe_o); // R11
endmodule

bind tw_sensor_port tw_sensor_port_chk #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
    .reg_sel_o(reg_sel_o), .reg_wr_en_o(reg_wr_en_o), .gc_reset_o(gc_reset_o),
    .any_read_o(any_read_o), .alert_win_o(alert_win_o));

// File: tb/tb_tw_sensor_port.sv
module tb_tw_sensor_port;
    localparam int TMO = 2000;
    localparam int Q   = 10;
    localparam logic [1:0] STRAP = 2'b10;
    localparam logic [6:0] OWN   = {5'b10010, STRAP};
    // {pointer, written word, expected read-back}
    localparam logic [33:0] VEC [4] = '{
        {2'd1, 16'h6A20, 16'h6A20},
        {2'd2, 16'h4B00, 16'h4B00},
        {2'd3, 16'h5000, 16'h5000},
        {2'd0, 16'hFFFF, 16'h1900}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1, rival_low = 1'b0;
    logic alert = 1'b0, cause = 1'b0;
    logic sda_oe, wr_en, wr_hi, gc_rst, any_rd, win;
    logic [1:0] sel;
    logic [7:0] wr_data;
    logic [15:0] rd_data;
    logic sda_line;
    logic [15:0] regs [4];
    int wr_cnt, gc_cnt, rd_cnt, win_cnt;
    int checks = 0, errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    assign sda_line = m_sda & ~sda_oe & ~rival_low;
    assign rd_data  = regs[sel];

    tw_sensor_port #(.TIMEOUT_TICKS(TMO)) dut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
        .strap_i(STRAP), .alert_i(alert), .alert_cause_i(cause),
        .reg_sel_o(sel), .reg_rd_data_i(rd_data), .reg_wr_en_o(wr_en),
        .reg_wr_hi_o(wr_hi), .reg_wr_data_o(wr_data), .gc_reset_o(gc_rst),
        .any_read_o(any_rd), .alert_win_o(win));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs[0] <= 16'h1900; regs[1] <= 16'h60A0;
            regs[2] <= 16'h4B00; regs[3] <= 16'h5000;
            wr_cnt <= 0; gc_cnt <= 0; rd_cnt <= 0; win_cnt <= 0;
        end else begin
            if (wr_en) begin
                if (wr_hi) regs[sel][15:8] <= wr_data;
                else       regs[sel][7:0]  <= wr_data;
                wr_cnt <= wr_cnt + 1;
            end
            if (gc_rst) gc_cnt  <= gc_cnt + 1;
            if (any_rd) rd_cnt  <= rd_cnt + 1;
            if (win)    win_cnt <= win_cnt + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n); repeat (n) @(negedge clk); endtask
    task automatic bus_start(); m_sda = 1; m_scl = 1; tick(Q); m_sda = 0; tick(Q); m_scl = 0; tick(Q); endtask
    task automatic bus_rstart(); m_sda = 1; tick(Q); m_scl = 1; tick(Q); m_sda = 0; tick(Q); m_scl = 0; tick(Q); endtask
    task automatic bus_stop(); m_sda = 0; tick(Q); m_scl = 1; tick(Q); m_sda = 1; tick(2*Q); endtask
    task automatic put_bit(input logic b); m_sda = b; tick(Q); m_scl = 1; tick(2*Q); m_scl = 0; tick(Q); endtask
    task automatic get_bit(output logic b); m_sda = 1; tick(Q); m_scl = 1; tick(Q); b = sda_line; tick(Q); m_scl = 0; tick(Q); endtask

    task automatic put_byte(input logic [7:0] d, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(b);
        acked = !b;
    endtask

    task automatic get_byte(output logic [7:0] d, input logic mack);
        logic b;
        logic [7:0] t;
        for (int i = 7; i >= 0; i--) begin get_bit(b); t[i] = b; end
        put_bit(!mack);
        d = t;
    endtask

    task automatic rd_word(output logic [15:0] w, output logic acked);
        logic [7:0] hi, lo;
        bus_start();
        put_byte({OWN, 1'b1}, acked);
        get_byte(hi, 1'b1);
        get_byte(lo, 1'b0);
        bus_stop();
        w = {hi, lo};
    endtask

    task automatic wr_bytes(input logic [7:0] ptr, input logic [15:0] w, input int n, output int acks);
        logic a;
        acks = 0;
        bus_start();
        put_byte({OWN, 1'b0}, a); acks += int'(a);
        put_byte(ptr, a); acks += int'(a);
        if (n > 0) begin put_byte(w[15:8], a); acks += int'(a); end
        if (n > 1) begin put_byte(w[7:0], a); acks += int'(a); end
        bus_stop();
    endtask

    initial begin
        logic a, b, any_oe;
        logic [7:0] d;
        logic [15:0] w;
        int acks, base;

        tick(3);
        chk("R1 sda released in reset", sda_oe, 0);
        chk("R1 strobes idle in reset", {wr_en, gc_rst, any_rd, win}, 0);
        rst_n = 1;
        tick(20);
        chk("R1 pointer after reset", sel, 0);
        chk("R1 sda released after reset", sda_oe, 0);

        rd_word(w, a);
        chk("R2 own address ack", a, 1);
        chk("R3 R4 pointer 00 reads temperature", w, 16'h1900);
        chk("R4 any-read strobe", rd_cnt, 1);

        for (int k = 0; k < 4; k++) begin
            base = wr_cnt;
            wr_bytes({6'b0, VEC[k][33:32]}, VEC[k][31:16], 2, acks);
            tick(5);
            chk("R5 R6 all bytes acked", acks, 4);
            chk("R5 R6 write strobe count", wr_cnt - base, (VEC[k][33:32] == 2'd0) ? 0 : 2);
            rd_word(w, a);
            chk("R3 R4 R5 read-back", w, VEC[k][15:0]);
        end

        // partial write then pointer retained
        wr_bytes(8'h02, 16'h1200, 1, acks);
        rd_word(w, a);
        chk("R5 upper only, R3 pointer kept", w, 16'h1200);

        // NACK after first byte
        base = rd_cnt;
        bus_start();
        put_byte({OWN, 1'b1}, a);
        get_byte(d, 1'b0);
        bus_stop();
        chk("R4 single byte read", d, 8'h12);
        chk("R4 any-read on short read", rd_cnt - base, 1);
        rd_word(w, a);
        chk("R4 read after NACK", w, 16'h1200);

        // wrong strap address
        bus_start();
        put_byte({5'b10010, 2'b01, 1'b0}, a);
        bus_stop();
        chk("R2 foreign address nacked", a, 0);

        // general call
        bus_start();
        put_byte(8'h00, a); chk("R7 general call ack", a, 1);
        put_byte(8'h05, b); chk("R7 other command ack", b, 1);
        bus_stop();
        chk("R7 no reset on 0x05", gc_cnt, 0);
        chk("R7 pointer kept on 0x05", sel, 2);
        bus_start();
        put_byte(8'h00, a);
        put_byte(8'h06, b);
        bus_stop();
        chk("R7 reset strobe on 0x06", gc_cnt, 1);
        chk("R7 pointer back to 00", sel, 0);

        // Hs master code then repeated start
        bus_start();
        put_byte(8'h0A, a);
        chk("R10 master code nacked", a, 0);
        bus_rstart();
        put_byte({OWN, 1'b0}, a);
        chk("R10 address after repeated start", a, 1);
        put_byte(8'h01, b);
        bus_stop();
        chk("R10 pointer written after master code", sel, 1);

        // alert response, inactive
        alert = 0;
        bus_start();
        put_byte(8'h19, a);
        bus_stop();
        chk("R8 no ack while alert low", a, 0);

        // alert response, won
        alert = 1; cause = 1;
        bus_start();
        put_byte(8'h19, a);
        chk("R8 ack while alert high", a, 1);
        get_byte(d, 1'b0);
        chk("R8 reply byte", d, {OWN, 1'b1});
        bus_stop();
        tick(5);
        chk("R9 win strobe at stop", win_cnt, 1);

        // alert response, lost to a lower address
        cause = 0;
        bus_start();
        put_byte(8'h19, a);
        rival_low = 1;
        any_oe = 0;
        for (int i = 0; i < 8; i++) begin
            get_bit(b);
            if (i > 0) any_oe |= sda_oe;
        end
        rival_low = 0;
        put_bit(1'b1);
        bus_stop();
        tick(5);
        chk("R9 released after lost bit", any_oe, 0);
        chk("R9 no win strobe after loss", win_cnt, 1);
        alert = 0;

        // timeout mid-read, block driving a 0
        wr_bytes(8'h00, 16'h0, 0, acks);
        bus_start();
        put_byte({OWN, 1'b1}, a);
        chk("R12 driving data 0 with SCL low", sda_oe, 1);
        tick(TMO + 100);
        chk("R11 sda released after timeout", sda_oe, 0);
        bus_stop();
        rd_word(w, a);
        chk("R11 bus usable after timeout", w, 16'h1900);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
            $finish;
        end
    end
endmodule